// File: doc/BRIEF.md
# Execution Context Guard with Write-Triggered Syscall

This block keeps track of the execution context of a small soft CPU and enforces it from hardware alone. The context is firmware, syscall or application. It watches the instruction fetch bus and the data write bus of the core, and no software-written mode register exists. Firmware runs from an 8 KB ROM after reset. The first fetch from any address outside that ROM moves the core into application context on its own. From then on, ROM code may run only inside a syscall.

An application asks for a syscall by storing to any address in a reserved 16 MB window. That store raises the single syscall interrupt line of the core's minimal interrupt scheme. When the core acknowledges the interrupt by entering its handler, the context rises to syscall. The ROM handler then runs legally. Its return jump to code outside ROM drops the context back to application.

Two events are violations: a ROM fetch in application context, and a data write into the guard band at the base of firmware RAM, which sits just below the stack's lower bound. Either one sets a trap output that stays set until reset.

Top module: `exec_ctx_guard`

## Requirements
- R1: After reset, mode_o reads 0 (firmware), and both irq_o and trap_o are low.
- R2: A data write to any address from 0xE1000000 to 0xE1FFFFFF sets irq_o on the next clock edge. irq_o then stays high until an edge where irq_ack_i is high. A window write wins over an acknowledge in the same cycle. Writes outside the window, 0xE0FFFFFF and 0xE2000000 included, leave irq_o unchanged.
- R3: A valid fetch from an address outside the ROM (0x00000000 to 0x00001FFF, 8 KB) sets mode_o to 2 (application) on the next edge, unless irq_ack_i is high in the same cycle.
- R4: irq_ack_i high sets mode_o to 1 (syscall) on the next edge, from any context. It takes precedence over a fetch outside ROM in the same cycle.
- R5: A fetch from ROM in firmware or syscall context never sets trap_o. A ROM fetch in application context sets trap_o on the next edge, unless irq_ack_i is high in the same cycle.
- R6: A data write to the stack guard band, FW RAM base 0xD0000000 up to but excluding 0xD0000040, sets trap_o on the next edge. Writes at 0xD0000040 and above, and writes below 0xD0000000, do not.
- R7: Once set, trap_o stays high until reset, whatever the inputs do.
- R8: The block never returns to mode 0 except through reset. A ROM fetch in syscall context leaves mode_o at 1, and idle cycles in application context leave it at 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Instruction fetch issued this cycle |
| fetch_addr_i | input | 32 | Instruction fetch address |
| wr_valid_i | input | 1 | Data write issued this cycle |
| wr_addr_i | input | 32 | Data write address |
| irq_ack_i | input | 1 | Core enters the syscall handler this cycle |
| irq_o | output | 1 | Syscall interrupt request, level |
| mode_o | output | 2 | Context: 0 firmware, 1 syscall, 2 application |
| trap_o | output | 1 | Sticky access-violation trap |

## Verification
The assertions check every cycle for the single-step rules. They cover the next-edge reaction of the interrupt line to window writes and acknowledges, and the move to application on an out-of-ROM fetch. They also cover the rise to syscall on acknowledge, the trap on an application ROM fetch or a guard-band write, the stickiness of the trap, and the rule that firmware context is never re-entered. Only the bench scenarios show the window edges at exact addresses and the legal ROM sweep in firmware and syscall context. They also show whole sequences: leaving firmware, a syscall round trip back to application, and tie-breaks between simultaneous events followed through several cycles.

// File: rtl/exec_ctx_pkg.sv
package exec_ctx_pkg;
  typedef enum logic [1:0] {
    CTX_FW      = 2'd0,
    CTX_SYSCALL = 2'd1,
    CTX_APP     = 2'd2
  } ctx_e;
endpackage

// File: rtl/addr_window.sv
// Hit on an aligned power-of-two window.
module addr_window #(
  parameter int unsigned           ADDR_W  = 32,
  parameter logic [ADDR_W-1:0]     BASE    = '0,
  parameter int unsigned           SPAN_LG = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] SPAN_M1 = (ADDR_W'(1) << SPAN_LG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MASK    = ~SPAN_M1;

  assign hit_o = ((addr_i ^ BASE) & MASK) == '0;
endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
  import exec_ctx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_valid_i,
  input  logic fetch_in_rom_i,
  input  logic irq_ack_i,
  output ctx_e ctx_o
);
  ctx_e ctx_q, ctx_d;

  always_comb begin
    ctx_d = ctx_q;
    if (irq_ack_i)                          ctx_d = CTX_SYSCALL;
    else if (fetch_valid_i && !fetch_in_rom_i) ctx_d = CTX_APP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctx_q <= CTX_FW;
    else         ctx_q <= ctx_d;
  end

  assign ctx_o = ctx_q;
endmodule

// File: rtl/syscall_irq.sv
module syscall_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  logic wr_in_window_i,
  input  logic irq_ack_i,
  output logic irq_o
);
  logic irq_q;

  // new request wins over an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_q <= 1'b0;
    else if (wr_valid_i && wr_in_window_i) irq_q <= 1'b1;
    else if (irq_ack_i)                    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/trap_mon.sv
module trap_mon
  import exec_ctx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctx_e ctx_i,
  input  logic fetch_valid_i,
  input  logic fetch_in_rom_i,
  input  logic irq_ack_i,
  input  logic wr_valid_i,
  input  logic wr_in_guard_i,
  output logic trap_o
);
  logic rom_viol, stack_viol, trap_q;

  // handler entry fetches ROM while context still reads application
  assign rom_viol   = fetch_valid_i && fetch_in_rom_i && (ctx_i == CTX_APP) && !irq_ack_i;
  assign stack_viol = wr_valid_i && wr_in_guard_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    trap_q <= 1'b0;
    else if (rom_viol || stack_viol) trap_q <= 1'b1;
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/exec_ctx_guard.sv
module exec_ctx_guard
  import exec_ctx_pkg::*;
#(
  parameter int unsigned       ADDR_W            = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE          = 32'h0000_0000,
  parameter int unsigned       ROM_BYTES         = 8192,
  parameter logic [ADDR_W-1:0] FWRAM_BASE        = 32'hD000_0000,
  parameter int unsigned       STACK_GUARD_BYTES = 64,
  parameter logic [ADDR_W-1:0] SYSCALL_BASE      = 32'hE100_0000,
  parameter int unsigned       SYSCALL_BYTES     = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [1:0]        mode_o,
  output logic              trap_o
);
  localparam int unsigned ROM_LG   = $clog2(ROM_BYTES);
  localparam int unsigned GUARD_LG = $clog2(STACK_GUARD_BYTES);
  localparam int unsigned SYS_LG   = $clog2(SYSCALL_BYTES);

  logic fetch_in_rom, wr_in_sys, wr_in_guard;
  ctx_e ctx;

  addr_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .SPAN_LG(ROM_LG)) i_rom_win (
    .addr_i(fetch_addr_i), .hit_o(fetch_in_rom)
  );

  addr_window #(.ADDR_W(ADDR_W), .BASE(SYSCALL_BASE), .SPAN_LG(SYS_LG)) i_sys_win (
    .addr_i(wr_addr_i), .hit_o(wr_in_sys)
  );

  // guard band at FW RAM base, directly below the stack's lower bound
  addr_window #(.ADDR_W(ADDR_W), .BASE(FWRAM_BASE), .SPAN_LG(GUARD_LG)) i_guard_win (
    .addr_i(wr_addr_i), .hit_o(wr_in_guard)
  );

  ctx_fsm i_ctx_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_in_rom_i (fetch_in_rom),
    .irq_ack_i      (irq_ack_i),
    .ctx_o          (ctx)
  );

  syscall_irq i_syscall_irq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_valid_i     (wr_valid_i),
    .wr_in_window_i (wr_in_sys),
    .irq_ack_i      (irq_ack_i),
    .irq_o          (irq_o)
  );

  trap_mon i_trap_mon (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctx_i          (ctx),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_in_rom_i (fetch_in_rom),
    .irq_ack_i      (irq_ack_i),
    .wr_valid_i     (wr_valid_i),
    .wr_in_guard_i  (wr_in_guard),
    .trap_o         (trap_o)
  );

  assign mode_o = ctx;
endmodule

// File: rtl/exec_ctx_guard_chk.sv
module exec_ctx_guard_chk #(
  parameter int unsigned       ADDR_W            = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE          = 32'h0000_0000,
  parameter int unsigned       ROM_BYTES         = 8192,
  parameter logic [ADDR_W-1:0] FWRAM_BASE        = 32'hD000_0000,
  parameter int unsigned       STACK_GUARD_BYTES = 64,
  parameter logic [ADDR_W-1:0] SYSCALL_BASE      = 32'hE100_0000,
  parameter int unsigned       SYSCALL_BYTES     = 32'h0100_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              irq_ack_i,
  input logic              irq_o,
  input logic [1:0]        mode_o,
  input logic              trap_o
);
  logic in_rom, in_sys, in_guard;

  assign in_rom   = (fetch_addr_i >= ROM_BASE) &&
                    ((fetch_addr_i - ROM_BASE) < ADDR_W'(ROM_BYTES));
  assign in_sys   = (wr_addr_i >= SYSCALL_BASE) &&
                    ((wr_addr_i - SYSCALL_BASE) < ADDR_W'(SYSCALL_BYTES));
  assign in_guard = (wr_addr_i >= FWRAM_BASE) &&
                    ((wr_addr_i - FWRAM_BASE) < ADDR_W'(STACK_GUARD_BYTES));

  p_irq_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && in_sys) |=> irq_o);

  p_irq_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !(wr_valid_i && in_sys)) |=> !irq_o);

  p_app_on_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !in_rom && !irq_ack_i) |=> (mode_o == 2'd2));

  p_ack_syscall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> (mode_o == 2'd1));

  p_rom_in_app_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && in_rom && mode_o == 2'd2 && !irq_ack_i) |=> trap_o);

  p_stack_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && in_guard) |=> trap_o);

  p_trap_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> trap_o);

  p_no_fw_return_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |=> (mode_o != 2'd0));

  p_mode_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

bind exec_ctx_guard exec_ctx_guard_chk #(
  .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES),
  .FWRAM_BASE(FWRAM_BASE), .STACK_GUARD_BYTES(STACK_GUARD_BYTES),
  .SYSCALL_BASE(SYSCALL_BASE), .SYSCALL_BYTES(SYSCALL_BYTES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i),
  .fetch_addr_i(fetch_addr_i), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
  .irq_ack_i(irq_ack_i), .irq_o(irq_o), .mode_o(mode_o), .trap_o(trap_o)
);

// File: tb/test_exec_ctx_guard.sv
`timescale 1ns/1ps
module test_exec_ctx_guard;
  localparam logic [31:0] ROM_END   = 32'h0000_2000;
  localparam logic [31:0] SYS_LO    = 32'hE100_0000;
  localparam logic [31:0] SYS_HI    = 32'hE1FF_FFFF;
  localparam logic [31:0] GUARD_LO  = 32'hD000_0000;
  localparam logic [31:0] GUARD_END = 32'hD000_0040;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic        irq_ack_i = 1'b0;
  logic        irq_o, trap_o;
  logic [1:0]  mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] e_mode;
  logic       e_irq, e_trap;

  always #2.5 clk = ~clk;

  exec_ctx_guard i_exec_ctx_guard (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i(fetch_addr_i), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .irq_ack_i(irq_ack_i), .irq_o(irq_o), .mode_o(mode_o), .trap_o(trap_o)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "mode_o", int'(mode_o), int'(e_mode));
    cmp(tag, "irq_o",  int'(irq_o),  int'(e_irq));
    cmp(tag, "trap_o", int'(trap_o), int'(e_trap));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; fetch_valid_i = 1'b0; wr_valid_i = 1'b0; irq_ack_i = 1'b0;
    fetch_addr_i = '0; wr_addr_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    e_mode = 2'd0; e_irq = 1'b0; e_trap = 1'b0;
    #1 check_all("R1");
  endtask

  // one cycle of stimulus; expected state follows the requirements
  task automatic step(input logic fv, input logic [31:0] fa, input logic wv,
                      input logic [31:0] wa, input logic ak, input string tag);
    logic in_rom, in_sys, in_guard;
    logic [1:0] n_mode;
    logic n_irq, n_trap;
    @(negedge clk);
    fetch_valid_i = fv; fetch_addr_i = fa; wr_valid_i = wv; wr_addr_i = wa; irq_ack_i = ak;
    in_rom   = fa < ROM_END;
    in_sys   = (wa >= SYS_LO) && (wa <= SYS_HI);
    in_guard = (wa >= GUARD_LO) && (wa < GUARD_END);
    n_trap = e_trap | (fv && in_rom && e_mode == 2'd2 && !ak) | (wv && in_guard);
    n_irq  = (wv && in_sys) ? 1'b1 : (ak ? 1'b0 : e_irq);
    n_mode = ak ? 2'd1 : ((fv && !in_rom) ? 2'd2 : e_mode);
    @(posedge clk);
    #1;
    e_mode = n_mode; e_irq = n_irq; e_trap = n_trap;
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #(5ns * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    e_mode = 2'd0; e_irq = 1'b0; e_trap = 1'b0;
    do_reset();

    // R2: syscall window edges and interior, each followed by acknowledge
    for (int k = -3; k <= 3; k++) begin
      step(1'b0, '0, 1'b1, SYS_LO + 32'(k * 4), 1'b0, "R2");
      step(1'b0, '0, 1'b0, '0, 1'b1, "R2");
    end
    for (int k = -3; k <= 3; k++) begin
      step(1'b0, '0, 1'b1, SYS_HI + 32'(k), 1'b0, "R2");
      step(1'b0, '0, 1'b0, '0, 1'b1, "R2");
    end
    for (int k = 1; k < 16; k++) begin
      step(1'b0, '0, 1'b1, SYS_LO + 32'(k) * 32'h0010_0000, 1'b0, "R2");
      idle(1, "R2");
      step(1'b0, '0, 1'b0, '0, 1'b1, "R2");
    end
    // R2: write and acknowledge together keep the request
    step(1'b0, '0, 1'b1, SYS_LO, 1'b0, "R2");
    step(1'b0, '0, 1'b1, SYS_LO + 32'h40, 1'b1, "R2");
    step(1'b0, '0, 1'b0, '0, 1'b1, "R2");

    // R5: full ROM sweep in firmware context, no trap, stays firmware
    do_reset();
    for (int a = 0; a < 32'h2000; a += 4) step(1'b1, 32'(a), 1'b0, '0, 1'b0, "R5");
    // R3: first fetch past ROM end
    step(1'b1, ROM_END, 1'b0, '0, 1'b0, "R3");
    idle(3, "R8");
    // R5: ROM fetch in application context traps
    step(1'b1, ROM_END - 32'd4, 1'b0, '0, 1'b0, "R5");
    // R7: trap holds through further activity
    step(1'b0, '0, 1'b0, '0, 1'b1, "R7");
    step(1'b1, 32'h8000, 1'b1, 32'h0000_4000, 1'b0, "R7");
    idle(4, "R7");

    // R3/R4/R8: syscall round trip
    do_reset();
    step(1'b1, 32'h0001_0000, 1'b0, '0, 1'b0, "R3");
    step(1'b1, 32'h0001_0004, 1'b1, SYS_LO + 32'h123, 1'b0, "R2");
    step(1'b1, 32'h0000_0010, 1'b0, '0, 1'b1, "R4");
    for (int a = 16'h14; a < 16'h1000; a += 16'h124)
      step(1'b1, 32'(a), 1'b0, '0, 1'b0, "R8");
    step(1'b1, 32'h0001_0008, 1'b0, '0, 1'b0, "R3");
    idle(3, "R8");
    // R4: acknowledge beats an out-of-ROM fetch
    step(1'b1, 32'h0002_0000, 1'b0, '0, 1'b1, "R4");
    step(1'b1, 32'h0000_1FFC, 1'b0, '0, 1'b0, "R5");
    step(1'b1, ROM_END, 1'b0, '0, 1'b0, "R3");
    // R4: acknowledge straight from firmware context
    do_reset();
    step(1'b0, '0, 1'b0, '0, 1'b1, "R4");
    step(1'b1, 32'h0000_0100, 1'b0, '0, 1'b0, "R8");

    // R6: writes at and above the stack bound, and below FW RAM
    do_reset();
    for (int o = 32'h40; o < 32'h200; o += 4) step(1'b0, '0, 1'b1, GUARD_LO + 32'(o), 1'b0, "R6");
    step(1'b0, '0, 1'b1, GUARD_LO - 32'd4, 1'b0, "R6");
    step(1'b0, '0, 1'b1, GUARD_LO - 32'd1, 1'b0, "R6");
    step(1'b0, '0, 1'b1, GUARD_LO + 32'h3F, 1'b0, "R6");
    idle(2, "R7");
    for (int o = 0; o < 32'h40; o += 8) begin
      do_reset();
      step(1'b0, '0, 1'b1, GUARD_LO + 32'(o), 1'b0, "R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule